// File: doc/BRIEF.md
# Sub-flit permutation stage

This block sits in a network-on-chip datapath. It cuts each flit into equal sub-flits, and each output sub-flit can take any input sub-flit. Sub-flit 0 carries the least significant bits. Every output position has its own select register, written through a small configuration port. Two copies of the same module are used together. The first copy sits ahead of a path with known stuck bit lines and moves low-order sub-flits onto those lines. The second copy sits after the path, holds the inverse permutation and puts the sub-flits back in their original order. A permanent fault then corrupts only low-order bits. For example, in an 8-bit flit with 2-bit sub-flits and faults on bits 7 and 6, swapping sub-flits 0 and 3 limits the error to 0..3 instead of 0..192.

The flit path is purely combinational, and the valid flag travels beside the data. After reset every select register holds its own position, so flits pass through unchanged until a permutation is loaded.

Top module: `sfp_stage`

## Requirements
- R1: After reset, select register i holds i and flit_out equals flit_in for any input.
- R2: Output sub-flit i (bits i*SUB_W upward) equals input sub-flit k, where k is the value in select register i. The output follows the input in the same cycle, for any permutation.
- R3: flit_vld_out equals flit_vld_in in the same cycle, whatever the permutation.
- R4: A configuration write (cfg_we high, register index cfg_idx, value cfg_val) changes the output only after the next rising clock edge.
- R5: A write changes only the addressed register, and every other output sub-flit keeps its mapping.
- R6: A stage loaded with permutation P followed by a stage loaded with the inverse of P returns the original flit for every input.
- R7: With the shuffle stage swapping sub-flits 0 and N-1, the deshuffle stage swapping them back, and the top sub-flit's bit lines stuck at one between the two stages, the recovered flit differs from the original only within sub-flit 0.
- R8: While cfg_we is low, changes on cfg_idx and cfg_val leave every mapping unchanged.
- R9: FLIT_W and SUB_W are powers of two with SUB_W below FLIT_W. The stage works for 32-bit flits with both 4-bit and 8-bit sub-flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select registers |
| rst_n | input | 1 | Active-low reset; asserts at once, released on the clock |
| cfg_we | input | 1 | Write strobe for one select register |
| cfg_idx | input | log2(FLIT_W/SUB_W) | Output position whose select register is written |
| cfg_val | input | log2(FLIT_W/SUB_W) | Input sub-flit index to store |
| flit_in | input | FLIT_W | Incoming flit |
| flit_vld_in | input | 1 | Incoming valid flag |
| flit_out | output | FLIT_W | Permuted flit |
| flit_vld_out | output | 1 | Valid flag passed through |

## Verification
The hardest case to reach is the fault case. Mitigation only shows when a shuffle stage, a path with stuck bit lines and a deshuffle stage holding the exact inverse act together, and no single stage's ports can show it. The bench therefore chains two instances and forces the top sub-flit's lines high between them. It loads mirrored swaps into both stages and checks that only the low sub-flit of the recovered word changes. Write timing is checked by sampling the output before and after the edge that takes a write.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  function automatic int sfp_lanes(input int flit_w, input int sub_w);
    return flit_w / sub_w;
  endfunction

  function automatic bit sfp_is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/sfp_rst_sync.sv
module sfp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/sfp_sel_bank.sv
module sfp_sel_bank #(
  parameter int LANES = 8,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [IDX_W-1:0]       wr_val,
  output logic [LANES*IDX_W-1:0] sel_flat
);
  for (genvar r = 0; r < LANES; r++) begin : g_reg
    localparam logic [IDX_W-1:0] HOME = IDX_W'(r);
    logic             hit;
    logic [IDX_W-1:0] sel_d;
    logic [IDX_W-1:0] sel_q;

    assign hit = wr_en && (wr_idx == HOME);

    always_comb begin
      sel_d = sel_q;
      if (hit) sel_d = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q <= HOME;
      end else if (hit) begin
        sel_q <= sel_d;
      end
    end

    assign sel_flat[r*IDX_W +: IDX_W] = sel_q;
  end
endmodule

// File: rtl/sfp_lane_mux.sv
module sfp_lane_mux #(
  parameter int LANES = 8,
  parameter int SUB_W = 4,
  parameter int IDX_W = 3
) (
  input  logic [LANES*SUB_W-1:0] flit,
  input  logic [IDX_W-1:0]       sel,
  output logic [SUB_W-1:0]       lane
);
  always_comb begin
    lane = '0;
    for (int k = 0; k < LANES; k++) begin
      if (sel == IDX_W'(k)) lane = flit[k*SUB_W +: SUB_W];
    end
  end
endmodule

// File: rtl/sfp_stage.sv
module sfp_stage #(
  parameter int FLIT_W = 32,
  parameter int SUB_W  = 4,
  localparam int LANES = sfp_pkg::sfp_lanes(FLIT_W, SUB_W),
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [IDX_W-1:0]  cfg_val,
  input  logic [FLIT_W-1:0] flit_in,
  input  logic              flit_vld_in,
  output logic [FLIT_W-1:0] flit_out,
  output logic              flit_vld_out
);
  if (!sfp_pkg::sfp_is_pow2(FLIT_W) || !sfp_pkg::sfp_is_pow2(SUB_W) || SUB_W >= FLIT_W) begin : g_bad
    $error("sfp_stage: widths must be powers of two with SUB_W < FLIT_W");
  end

  logic                   rst_sync_n;
  logic [LANES*IDX_W-1:0] sel_flat;

  sfp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sfp_sel_bank #(.LANES(LANES), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_val   (cfg_val),
    .sel_flat (sel_flat)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sfp_lane_mux #(.LANES(LANES), .SUB_W(SUB_W), .IDX_W(IDX_W)) u_mux (
      .flit (flit_in),
      .sel  (sel_flat[i*IDX_W +: IDX_W]),
      .lane (flit_out[i*SUB_W +: SUB_W])
    );
  end

  assign flit_vld_out = flit_vld_in;
endmodule

// File: rtl/sfp_stage_chk.sv
module sfp_stage_chk #(
  parameter int FLIT_W = 32,
  parameter int SUB_W  = 4,
  localparam int LANES = FLIT_W / SUB_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   cfg_we,
  input logic [IDX_W-1:0]       cfg_idx,
  input logic [IDX_W-1:0]       cfg_val,
  input logic [LANES*IDX_W-1:0] sel_flat,
  input logic [FLIT_W-1:0]      flit_in,
  input logic [FLIT_W-1:0]      flit_out
);
  function automatic logic [LANES*IDX_W-1:0] home_map();
    logic [LANES*IDX_W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*IDX_W +: IDX_W] = IDX_W'(i);
    return v;
  endfunction

  localparam logic [LANES*IDX_W-1:0] HOME = home_map();

  logic             prev_we_q;
  logic [IDX_W-1:0] prev_idx_q;
  logic [IDX_W-1:0] prev_val_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prev_we_q  <= 1'b0;
      prev_idx_q <= '0;
      prev_val_q <= '0;
    end else begin
      prev_we_q  <= cfg_we;
      prev_idx_q <= cfg_idx;
      prev_val_q <= cfg_val;
    end
  end

  always @(negedge clk) begin
    if (!rst_sync_n) begin
      AST_RESET_HOME: assert (sel_flat == HOME); // R1
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    prev_we_q |-> (sel_flat[prev_idx_q*IDX_W +: IDX_W] == prev_val_q)); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_we |=> $stable(sel_flat)); // R8

  AST_HOME_PASSES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_flat == HOME) |-> (flit_out == flit_in)); // R1
endmodule

bind sfp_stage sfp_stage_chk #(.FLIT_W(FLIT_W), .SUB_W(SUB_W)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_we     (cfg_we),
  .cfg_idx    (cfg_idx),
  .cfg_val    (cfg_val),
  .sel_flat   (sel_flat),
  .flit_in    (flit_in),
  .flit_out   (flit_out)
);

// File: tb/sfp_stage_tb_top.sv
module sfp_stage_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;

  logic        we_a, we_b, we_c;
  logic [2:0]  idx_a, val_a, idx_b, val_b;
  logic [1:0]  idx_c, val_c;
  logic [31:0] din, shuf_out, faulty, rec_out, w8_out;
  logic        vin, vout_a, vout_b, vout_c;
  logic [31:0] stuck_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sfp_stage #(.FLIT_W(32), .SUB_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_a), .cfg_idx(idx_a), .cfg_val(val_a),
    .flit_in(din), .flit_vld_in(vin), .flit_out(shuf_out), .flit_vld_out(vout_a));

  assign faulty = shuf_out | stuck_mask;

  sfp_stage #(.FLIT_W(32), .SUB_W(4)) dsh_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_b), .cfg_idx(idx_b), .cfg_val(val_b),
    .flit_in(faulty), .flit_vld_in(vout_a), .flit_out(rec_out), .flit_vld_out(vout_b));

  sfp_stage #(.FLIT_W(32), .SUB_W(8)) w8_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_c), .cfg_idx(idx_c), .cfg_val(val_c),
    .flit_in(din), .flit_vld_in(vin), .flit_out(w8_out), .flit_vld_out(vout_c));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] permute(input logic [31:0] d, input int sel[8],
                                          input int lanes, input int w);
    logic [31:0] o = '0;
    for (int i = 0; i < lanes; i++)
      for (int b = 0; b < w; b++) o[i*w+b] = d[sel[i]*w+b];
    return o;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr_a(input int idx, input int val);
    @(negedge clk); we_a = 1; idx_a = 3'(idx); val_a = 3'(val);
    @(negedge clk); we_a = 0;
  endtask
  task automatic wr_b(input int idx, input int val);
    @(negedge clk); we_b = 1; idx_b = 3'(idx); val_b = 3'(val);
    @(negedge clk); we_b = 0;
  endtask
  task automatic wr_c(input int idx, input int val);
    @(negedge clk); we_c = 1; idx_c = 2'(idx); val_c = 2'(val);
    @(negedge clk); we_c = 0;
  endtask

  task automatic t_reset_home();
    logic [31:0] pats[3] = '{32'hDEADBEEF, 32'h0123_4567, 32'hF0F0_0F0F};
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); din = pats[p]; vin = p[0]; #1;
      check("R1 home map 4-bit", shuf_out, pats[p]);
      check("R1 home map 8-bit", w8_out, pats[p]);
      check("R3 valid follows", {31'b0, vout_a}, {31'b0, p[0]});
    end
  endtask

  task automatic t_write_timing();
    int sel[8] = '{7, 1, 2, 3, 4, 5, 6, 7};
    @(negedge clk); din = 32'h8765_4321;
    we_a = 1; idx_a = 3'd0; val_a = 3'd7; #1;
    check("R4 no change before edge", shuf_out, 32'h8765_4321);
    @(negedge clk); we_a = 0; #1;
    check("R4 write after edge", shuf_out, permute(32'h8765_4321, sel, 8, 4));
    check("R5 other lanes kept", shuf_out & 32'hFFFF_FFF0, 32'h8765_4320);
    wr_a(0, 0);
  endtask

  task automatic t_idle_ignored();
    @(negedge clk); din = 32'hA5A5_1234; we_a = 0;
    for (int k = 0; k < 4; k++) begin
      idx_a = 3'(k); val_a = 3'(7 - k);
      @(negedge clk);
    end
    #1;
    check("R8 idle cfg ignored", shuf_out, 32'hA5A5_1234);
  endtask

  task automatic t_reverse_perm();
    int sel[8] = '{7, 6, 5, 4, 3, 2, 1, 0};
    logic [31:0] pats[4] = '{32'h0123_4567, 32'hFFFF_0000, 32'h1000_0001, 32'hCAFE_F00D};
    for (int i = 0; i < 8; i++) wr_a(i, sel[i]);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); din = pats[p]; vin = 1; #1;
      check("R2 reversed lanes", shuf_out, permute(pats[p], sel, 8, 4));
    end
    vin = 0; #1;
    check("R3 valid low passes", {31'b0, vout_a}, 32'd0);
  endtask

  task automatic t_roundtrip();
    int p[8]   = '{3, 0, 7, 5, 1, 6, 2, 4};
    int inv[8];
    logic [31:0] pats[3] = '{32'h1357_9BDF, 32'h8000_0001, 32'h7E7E_8181};
    for (int i = 0; i < 8; i++) inv[p[i]] = i;
    for (int i = 0; i < 8; i++) begin wr_a(i, p[i]); wr_b(i, inv[i]); end
    stuck_mask = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); din = pats[k]; #1;
      check("R6 inverse restores", rec_out, pats[k]);
    end
  endtask

  task automatic t_fault();
    int sw[8] = '{7, 1, 2, 3, 4, 5, 6, 0};
    for (int i = 0; i < 8; i++) begin wr_a(i, sw[i]); wr_b(i, sw[i]); end
    stuck_mask = 32'hF000_0000;
    @(negedge clk); din = 32'h1234_5670; #1;
    check("R7 fault lands in low lane", rec_out, 32'h1234_567F);
    @(negedge clk); din = 32'h0BAD_CAFE; #1;
    check("R7 high lanes intact", rec_out & 32'hFFFF_FFF0, 32'h0BAD_CAF0);
    stuck_mask = '0;
  endtask

  task automatic t_wide_lanes();
    int sel[8] = '{1, 2, 3, 0, 0, 0, 0, 0};
    for (int i = 0; i < 4; i++) wr_c(i, sel[i]);
    @(negedge clk); din = 32'hAABB_CCDD; #1;
    check("R9 8-bit lanes rotate", w8_out, permute(32'hAABB_CCDD, sel, 4, 8));
    check("R2 8-bit lanes literal", w8_out, 32'hDDAA_BBCC);
  endtask

  initial begin
    rst_n = 0; we_a = 0; we_b = 0; we_c = 0;
    idx_a = 0; val_a = 0; idx_b = 0; val_b = 0; idx_c = 0; val_c = 0;
    din = 0; vin = 0; stuck_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset_home();
    t_write_timing();
    t_idle_ignored();
    t_reverse_perm();
    t_roundtrip();
    t_fault();
    t_wide_lanes();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule